// File: doc/BRIEF.md
# Replay FIFO with Half-Occupancy Flag

This block is a single-clock, 9-bit-wide first-in first-out buffer. A producer writes words with an active-low write enable. A consumer pulls them back in the same order with an active-low read enable. The storage depth is a power-of-two parameter. Real builds use thousands of words, and simulation uses a handful. Three active-low flags report occupancy:
- `empty_n` when no word is stored.
- `half_n` when more than half of the storage holds data.
- `full_n` when every location holds data.

A write to a full buffer is dropped, and so is a read from an empty one. The read port has no high-impedance state. It carries a `rvalid` qualifier that is high only in the cycle after an accepted read.

A replay input lets a consumer receive the same packet again. When `replay_n` is pulsed low with both enables idle, the read address returns to physical location zero. Occupancy then becomes the number of writes since reset, saturated at the depth, and the flags follow from that value. Later reads deliver the stored words again, and then any words written after the replay. A replay request made while either enable is active is discarded.

Occupancy is tracked by a four-state machine:
- `ST_EMPTY`: nothing stored.
- `ST_LOWER`: 1 to DEPTH/2 words.
- `ST_UPPER`: DEPTH/2+1 to DEPTH-1 words.
- `ST_FULL`: DEPTH words.

Its transitions are:
- Fill: `ST_EMPTY`→`ST_LOWER` on a write.
- Rise: `ST_LOWER`→`ST_UPPER` on a lone write at DEPTH/2.
- Top-off: `ST_UPPER`→`ST_FULL` on a lone write at DEPTH-1.
- Drain-from-full: `ST_FULL`→`ST_UPPER` on a read.
- Fall: `ST_UPPER`→`ST_LOWER` on a lone read at DEPTH/2+1.
- Drain: `ST_LOWER`→`ST_EMPTY` on a lone read at 1.
- Rewind: any state → the state that matches the saturated write count, on an accepted replay.

Top module: `fifo_hf_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with no traffic, `empty_n`=0, `half_n`=1, `full_n`=1 and `rvalid`=0.
- R2: An accepted read (`rd_n`=0 while not empty) raises `rvalid` on the next clock edge, with `rdata` equal to the oldest unread word. Words leave in the order they were written.
- R3: A write while `full_n`=0 is discarded. The write address does not advance, and the word is never read out.
- R4: A read while `empty_n`=0 is discarded. `rvalid` stays 0 and the read address does not advance.
- R5: `full_n` goes low on the edge that accepts the write filling the last free location. It goes high again on the edge of the next accepted read.
- R6: `half_n` is low exactly when occupancy is at least DEPTH/2+1. It goes low on the write that reaches DEPTH/2+1 and high on the read that returns to DEPTH/2.
- R7: `empty_n` is low exactly when occupancy is zero.
- R8: An accepted replay (`replay_n`=0 with `wr_n`=1 and `rd_n`=1) moves the read address to physical location 0. The next read returns the first word written since reset.
- R9: After an accepted replay, occupancy equals the number of writes accepted since reset, saturated at DEPTH, and all three flags reflect that value on the following edge.
- R10: Words written after a replay are delivered in order once the replayed words have been read.
- R11: A replay request made while `wr_n` or `rd_n` is low is ignored. The read or write in that cycle proceeds as if `replay_n` were high.
- R12: With a simultaneous read and write, both are accepted when the buffer is neither empty nor full, leaving occupancy unchanged. When full, only the read is accepted. When empty, only the write is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the empty condition |
| wr_n | input | 1 | Active-low write enable |
| wdata | input | 9 | Word to store |
| rd_n | input | 1 | Active-low read enable |
| rdata | output | 9 | Word read out, meaningful when `rvalid` is high |
| rvalid | output | 1 | High for one cycle after each accepted read |
| replay_n | input | 1 | Active-low request to rewind the read address to location 0 |
| empty_n | output | 1 | Low when no word is stored |
| half_n | output | 1 | Low when occupancy exceeds half the depth |
| full_n | output | 1 | Low when every location is occupied |

## Verification
Every result is one register stage away from its cause:
- Flags, `rvalid` and `rdata` all change on the same rising edge that samples the write, read or replay request.
- A replay's new flag values appear on the edge that accepts it.
- The read that follows a replay returns the location-0 word one edge later.

The bench drives each request just after a falling edge and lets exactly one rising edge pass. It then compares all outputs at the next falling edge, so each expected value is taken in the single cycle where the requirement places it.

// File: rtl/fifo_hf_pkg.sv
package fifo_hf_pkg;

    localparam int unsigned WORD_W = 9;

    // Occupancy regions used by the flag state machine.
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_LOWER = 2'd1,
        ST_UPPER = 2'd2,
        ST_FULL  = 2'd3
    } occ_state_e;

    // Region that a given occupancy belongs to (used on rewind).
    function automatic occ_state_e region_of(input int unsigned occ,
                                             input int unsigned depth);
        occ_state_e r;
        if (occ == 0)
            r = ST_EMPTY;
        else if (occ <= depth / 2)
            r = ST_LOWER;
        else if (occ < depth)
            r = ST_UPPER;
        else
            r = ST_FULL;
        return r;
    endfunction

endpackage

// File: rtl/fifo_hf_store.sv
module fifo_hf_store
    import fifo_hf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i)
            mem_q[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= re_i;
            if (re_i)
                rdata_o <= mem_q[raddr_i];
        end
    end

endmodule

// File: rtl/fifo_hf_ptrs.sv
module fifo_hf_ptrs #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc_i,
    input  logic          rd_acc_i,
    input  logic          rewind_i,
    output logic [AW-1:0] waddr_o,
    output logic [AW-1:0] raddr_o,
    output logic [CW-1:0] occ_o,
    output logic [CW-1:0] wsum_o
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    // Write address: advances only on an accepted write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            waddr_o <= '0;
        else if (wr_acc_i)
            waddr_o <= waddr_o + 1'b1;
    end

    // Read address: rewinds to physical location zero on replay.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            raddr_o <= '0;
        else if (rewind_i)
            raddr_o <= '0;
        else if (rd_acc_i)
            raddr_o <= raddr_o + 1'b1;
    end

    // Writes since reset, saturated at the depth.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wsum_o <= '0;
        else if (wr_acc_i && (wsum_o != DEPTH_C))
            wsum_o <= wsum_o + 1'b1;
    end

    // Occupancy: distance from read address to write address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            occ_o <= '0;
        else if (rewind_i)
            occ_o <= wsum_o;
        else begin
            unique case ({wr_acc_i, rd_acc_i})
                2'b10:   occ_o <= occ_o + 1'b1;
                2'b01:   occ_o <= occ_o - 1'b1;
                default: occ_o <= occ_o;
            endcase
        end
    end

    // R9: replay sets occupancy to the saturated write count
    p_rewind_occ_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_i |=> (occ_o == $past(wsum_o)));

    // R9: saturated write count never exceeds the depth
    p_wsum_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wsum_o <= DEPTH_C));

endmodule

// File: rtl/fifo_hf_flagfsm.sv
module fifo_hf_flagfsm
    import fifo_hf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1,
    localparam int unsigned HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ_i,
    input  logic [CW-1:0] wsum_i,
    input  logic          wr_acc_i,
    input  logic          rd_acc_i,
    input  logic          rewind_i,
    output logic          room_o,
    output logic          avail_o,
    output logic          empty_n,
    output logic          half_n,
    output logic          full_n
);

    localparam logic [CW-1:0] ONE_C   = CW'(1);
    localparam logic [CW-1:0] HALF_C  = CW'(HALF);
    localparam logic [CW-1:0] HALF1_C = CW'(HALF + 1);
    localparam logic [CW-1:0] TOP_C   = CW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    occ_state_e state_q, state_d;

    logic lone_wr, lone_rd;
    assign lone_wr = wr_acc_i && !rd_acc_i;
    assign lone_rd = rd_acc_i && !wr_acc_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (rewind_i) begin
            state_d = region_of(int'(wsum_i), DEPTH);           // rewind
        end else begin
            unique case (state_q)
                ST_EMPTY: if (wr_acc_i) state_d = ST_LOWER;    // fill
                ST_LOWER: begin
                    if (lone_wr && occ_i == HALF_C)
                        state_d = ST_UPPER;                    // rise
                    else if (lone_rd && occ_i == ONE_C)
                        state_d = ST_EMPTY;                    // drain
                end
                ST_UPPER: begin
                    if (lone_wr && occ_i == TOP_C)
                        state_d = ST_FULL;                     // top-off
                    else if (lone_rd && occ_i == HALF1_C)
                        state_d = ST_LOWER;                    // fall
                end
                ST_FULL:  if (rd_acc_i) state_d = ST_UPPER;    // drain-from-full
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin empty_n = 1'b0; half_n = 1'b1; full_n = 1'b1; end
            ST_LOWER: begin empty_n = 1'b1; half_n = 1'b1; full_n = 1'b1; end
            ST_UPPER: begin empty_n = 1'b1; half_n = 1'b0; full_n = 1'b1; end
            ST_FULL:  begin empty_n = 1'b1; half_n = 1'b0; full_n = 1'b0; end
        endcase
        room_o  = full_n;
        avail_o = empty_n;
    end

    // R7: empty state tracks zero occupancy
    p_empty_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) == (occ_i == '0));

    // R6: upper region tracks occupancy above half and below full
    p_upper_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPPER) == ((occ_i > HALF_C) && (occ_i < DEPTH_C)));

    // R5: full state tracks occupancy at depth
    p_full_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == (occ_i == DEPTH_C));

endmodule

// File: rtl/fifo_hf_top.sv
module fifo_hf_top
    import fifo_hf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_n,
    input  logic [8:0]  wdata,
    input  logic        rd_n,
    output logic [8:0]  rdata,
    output logic        rvalid,
    input  logic        replay_n,
    output logic        empty_n,
    output logic        half_n,
    output logic        full_n
);

    logic          room, avail;
    logic          wr_acc, rd_acc, rewind;
    logic [AW-1:0] waddr, raddr;
    logic [CW-1:0] occ, wsum;

    assign wr_acc = !wr_n && room;
    assign rd_acc = !rd_n && avail;
    assign rewind = !replay_n && wr_n && rd_n;

    fifo_hf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc_i (wr_acc),
        .rd_acc_i (rd_acc),
        .rewind_i (rewind),
        .waddr_o  (waddr),
        .raddr_o  (raddr),
        .occ_o    (occ),
        .wsum_o   (wsum)
    );

    fifo_hf_flagfsm #(.DEPTH(DEPTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .occ_i    (occ),
        .wsum_i   (wsum),
        .wr_acc_i (wr_acc),
        .rd_acc_i (rd_acc),
        .rewind_i (rewind),
        .room_o   (room),
        .avail_o  (avail),
        .empty_n  (empty_n),
        .half_n   (half_n),
        .full_n   (full_n)
    );

    fifo_hf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wr_acc),
        .waddr_i  (waddr),
        .wdata_i  (wdata),
        .re_i     (rd_acc),
        .raddr_i  (raddr),
        .rdata_o  (rdata),
        .rvalid_o (rvalid)
    );

    // R2: a read while data is stored yields valid data next cycle
    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && empty_n) |=> rvalid);

    // R3: write while full leaves the write address alone
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !wr_n) |=> $stable(waddr));

    // R4: read while empty gives no data and keeps the read address
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rd_n) |=> (!rvalid && $stable(raddr)));

    // R8: accepted replay rewinds the read address to location 0
    p_rewind_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!replay_n && wr_n && rd_n) |=> (raddr == '0));

    // R11: replay during an active read does not block the read
    p_replay_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!replay_n && !rd_n && empty_n) |=> rvalid);

endmodule

// File: tb/fifo_hf_top_tb_top.sv
`timescale 1ns/1ps
module fifo_hf_top_tb_top;

    localparam int unsigned DEPTH = 8;
    localparam int NVEC = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       replay_n = 1'b1;
    logic [8:0] wdata = '0;
    logic [8:0] rdata;
    logic       rvalid, empty_n, half_n, full_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fifo_hf_top #(.DEPTH(DEPTH)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .wdata    (wdata),
        .rd_n     (rd_n),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .replay_n (replay_n),
        .empty_n  (empty_n),
        .half_n   (half_n),
        .full_n   (full_n)
    );

    typedef struct packed {
        logic [3:0] tag;   // requirement number checked by this row
        logic       wr;
        logic       rd;
        logic [8:0] din;
        logic       ev;
        logic [8:0] dout;
        logic       emp;
        logic       hf;
        logic       ful;
    } vec_t;

    // tag, wr, rd, din, exp_valid, exp_data, exp_empty, exp_half, exp_full
    localparam vec_t TBL [NVEC] = '{
        {4'd4,  1'b0, 1'b1, 9'h000, 1'b0, 9'h000, 1'b1, 1'b0, 1'b0}, // R4 read empty
        {4'd7,  1'b1, 1'b0, 9'h101, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0}, // R7 occ 1
        {4'd2,  1'b1, 1'b0, 9'h0A2, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0},
        {4'd2,  1'b1, 1'b0, 9'h1F3, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0},
        {4'd6,  1'b1, 1'b0, 9'h004, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0}, // R6 occ 4, half stays high
        {4'd6,  1'b1, 1'b0, 9'h155, 1'b0, 9'h000, 1'b0, 1'b1, 1'b0}, // R6 occ 5
        {4'd6,  1'b0, 1'b1, 9'h000, 1'b1, 9'h101, 1'b0, 1'b0, 1'b0}, // R6 back to 4
        {4'd12, 1'b1, 1'b1, 9'h066, 1'b1, 9'h0A2, 1'b0, 1'b0, 1'b0}, // R12 both, occ 4
        {4'd6,  1'b1, 1'b0, 9'h077, 1'b0, 9'h000, 1'b0, 1'b1, 1'b0},
        {4'd2,  1'b1, 1'b0, 9'h088, 1'b0, 9'h000, 1'b0, 1'b1, 1'b0},
        {4'd2,  1'b1, 1'b0, 9'h099, 1'b0, 9'h000, 1'b0, 1'b1, 1'b0},
        {4'd5,  1'b1, 1'b0, 9'h0AA, 1'b0, 9'h000, 1'b0, 1'b1, 1'b1}, // R5 full
        {4'd3,  1'b1, 1'b0, 9'h1BB, 1'b0, 9'h000, 1'b0, 1'b1, 1'b1}, // R3 dropped
        {4'd12, 1'b1, 1'b1, 9'h0CC, 1'b1, 9'h1F3, 1'b0, 1'b1, 1'b0}, // R12 full: read only
        {4'd2,  1'b0, 1'b1, 9'h000, 1'b1, 9'h004, 1'b0, 1'b1, 1'b0},
        {4'd2,  1'b0, 1'b1, 9'h000, 1'b1, 9'h155, 1'b0, 1'b1, 1'b0},
        {4'd6,  1'b0, 1'b1, 9'h000, 1'b1, 9'h066, 1'b0, 1'b0, 1'b0},
        {4'd2,  1'b0, 1'b1, 9'h000, 1'b1, 9'h077, 1'b0, 1'b0, 1'b0},
        {4'd2,  1'b0, 1'b1, 9'h000, 1'b1, 9'h088, 1'b0, 1'b0, 1'b0},
        {4'd2,  1'b0, 1'b1, 9'h000, 1'b1, 9'h099, 1'b0, 1'b0, 1'b0},
        {4'd7,  1'b0, 1'b1, 9'h000, 1'b1, 9'h0AA, 1'b1, 1'b0, 1'b0}, // R7 empty again
        {4'd3,  1'b0, 1'b1, 9'h000, 1'b0, 9'h000, 1'b1, 1'b0, 1'b0}  // R3 no dropped word
    };

    task automatic expect_out(input string req, input bit ev, input logic [8:0] ed,
                              input bit emp, input bit hf, input bit ful);
        bit bad;
        checks++;
        bad = (rvalid !== ev) || (empty_n !== !emp) || (half_n !== !hf) ||
              (full_n !== !ful) || (ev && (rdata !== ed));
        if (bad) begin
            fails++;
            $display("FAIL %s: actual rvalid=%b rdata=%h empty_n=%b half_n=%b full_n=%b expected rvalid=%b rdata=%h empty_n=%b half_n=%b full_n=%b",
                     req, rvalid, rdata, empty_n, half_n, full_n, ev, ed, !emp, !hf, !ful);
        end
    endtask

    // Drive one request after a falling edge, pass one rising edge, settle at the next falling edge.
    task automatic step(input bit wr, input bit rd, input bit rp, input logic [8:0] d);
        wr_n = !wr; rd_n = !rd; replay_n = !rp; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; replay_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; replay_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R1: flags while reset is held
        @(negedge clk);
        expect_out("R1 during reset", 1'b0, 9'h000, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after release", 1'b0, 9'h000, 1'b1, 1'b0, 1'b0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i].wr, TBL[i].rd, 1'b0, TBL[i].din);
            expect_out($sformatf("R%0d table row %0d", TBL[i].tag, i),
                       TBL[i].ev, TBL[i].dout, TBL[i].emp, TBL[i].hf, TBL[i].ful);
        end

        // Partial replay: R8, R9, R10
        do_reset();
        step(1, 0, 0, 9'h011); step(1, 0, 0, 9'h022); step(1, 0, 0, 9'h033);
        step(0, 1, 0, 9'h000); expect_out("R2 first of three", 1'b1, 9'h011, 1'b0, 1'b0, 1'b0);
        step(0, 1, 0, 9'h000); expect_out("R2 second of three", 1'b1, 9'h022, 1'b0, 1'b0, 1'b0);
        step(0, 0, 1, 9'h000); expect_out("R9 flags after replay occ 3", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0);
        step(0, 1, 0, 9'h000); expect_out("R8 replay restarts at word 0", 1'b1, 9'h011, 1'b0, 1'b0, 1'b0);
        step(0, 1, 0, 9'h000); expect_out("R8 replay second word", 1'b1, 9'h022, 1'b0, 1'b0, 1'b0);
        step(0, 1, 0, 9'h000); expect_out("R8 replay last word", 1'b1, 9'h033, 1'b1, 1'b0, 1'b0);
        step(1, 0, 0, 9'h044); expect_out("R10 write after replay", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0);
        step(0, 1, 0, 9'h000); expect_out("R10 new word delivered", 1'b1, 9'h044, 1'b1, 1'b0, 1'b0);
        step(0, 1, 0, 9'h000); expect_out("R4 drained after replay", 1'b0, 9'h000, 1'b1, 1'b0, 1'b0);

        // Full replay and ignored requests: R9, R11
        do_reset();
        for (int k = 0; k < DEPTH; k++) step(1, 0, 0, 9'(9'h100 + k));
        expect_out("R5 full after depth writes", 1'b0, 9'h000, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < DEPTH; k++) begin
            step(0, 1, 0, 9'h000);
            expect_out("R2 drain order", 1'b1, 9'(9'h100 + k), (k == DEPTH - 1), (k < 3), 1'b0);
        end
        step(0, 0, 1, 9'h000); expect_out("R9 replay after depth writes gives full", 1'b0, 9'h000, 1'b0, 1'b1, 1'b1);
        step(0, 1, 0, 9'h000); expect_out("R8 full replay first word", 1'b1, 9'h100, 1'b0, 1'b1, 1'b0);
        step(0, 1, 1, 9'h000); expect_out("R11 replay with read ignored", 1'b1, 9'h101, 1'b0, 1'b1, 1'b0);
        step(1, 0, 1, 9'h1EE); expect_out("R11 replay with write ignored", 1'b0, 9'h000, 1'b0, 1'b1, 1'b0);
        step(0, 1, 0, 9'h000); expect_out("R11 read continues past rewind point", 1'b1, 9'h102, 1'b0, 1'b1, 1'b0);

        // R12: read and write together on an empty buffer
        do_reset();
        step(1, 1, 0, 9'h0F0); expect_out("R12 empty: write only", 1'b0, 9'h000, 1'b0, 1'b0, 1'b0);
        step(0, 1, 0, 9'h000); expect_out("R12 stored word returned", 1'b1, 9'h0F0, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule